// File: doc/BRIEF.md
# MSI capability and interrupt dispatcher

This block keeps a Message Signaled Interrupt capability structure, limited to 32-bit message addresses, inside a device's configuration space. It also decides how an internal interrupt event leaves the device. Configuration software reaches the structure through a DWord-wide read/write port. The port takes a DWord index and per-byte enables. Reads are combinational. Writes take effect at the next clock edge.

When message delivery is off, the interrupt event drives a level-sensitive legacy pin. When message delivery is on, the pin stays low, and each rising edge of the event becomes a single-cycle memory-write request. That request carries the programmed address and data. Messages also need the bus-master-enable bit of the device command register, which arrives as an input. With messages enabled and bus mastering off, nothing is delivered at all: no message and no pin.

A request counts as outstanding until the downstream logic acknowledges it. Event edges that arrive in the meantime are counted, and each one is released after an acknowledgement.

Top module: `msi_irq_dispatch`

## Requirements
- R1: After reset, DWord 20h (byte 80h) reads 0000_9005h, DWords 21h and 22h read 0, and msg_req and intx_o are low.
- R2: The identifier half of DWord 20h (bits 15:0) is read-only. Bits 7:0 always read 05h (the capability ID) and bits 15:8 always read 90h (the next-capability pointer), whatever is written.
- R3: The message control half of DWord 20h is bits 31:16. Bit 16 is message enable and bits 22:20 are the multiple-message-enable field, and both can be read and written. Bit 23 (64-bit capable), bits 19:17 (multiple-message capable) and bits 31:24 always read 0.
- R4: DWord 21h holds the message address. Bits 31:2 can be read and written, and bits 1:0 always read 0.
- R5: DWord 22h holds the message data. Bits 15:0 can be read and written, and bits 31:16 always read 0.
- R6: On a write, byte lane i (data bits 8i+7:8i) changes only when cfg_be[i] is 1.
- R7: Every DWord index other than 20h, 21h and 22h reads 0, and writes to it change no register.
- R8: With message enable 0, intx_o equals irq_event delayed by one clock, and msg_req stays low.
- R9: With message enable 1, intx_o is 0 whatever irq_event does.
- R10: With message enable 1 and bus_master_en 1, a rising edge of irq_event sampled at a clock edge makes msg_req high for exactly the following cycle, when no request is outstanding. During that cycle msg_addr and msg_data equal the address and data registers.
- R11: With message enable 1 and bus_master_en 0, a rising edge of irq_event produces neither msg_req nor intx_o.
- R12: A request stays outstanding until msg_ack is seen in a cycle after its pulse. An ack during the pulse cycle, or while nothing is outstanding, is ignored. Edges that arrive while a request is outstanding are counted, saturating at 2^CNT_W-1. Each accepted ack with a nonzero count issues the next pulse one cycle later. An accepted ack with a zero count ends the outstanding state.
- R13: The multiple-message-enable value has no effect: any value gives exactly one pulse per delivered event.
- R14: While message enable or bus_master_en is 0, the count of deferred edges is cleared, so an ack after re-enabling issues nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dword | input | 6 | DWord index of the configuration access (byte offset / 4) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_dword |
| bus_master_en | input | 1 | Bus-master-enable bit of the command register |
| irq_event | input | 1 | Internal interrupt condition (level) |
| msg_ack | input | 1 | Downstream acceptance of the outstanding message |
| msg_req | output | 1 | One-cycle message-write request |
| msg_addr | output | 32 | Message address, DWord aligned |
| msg_data | output | 16 | Message data |
| intx_o | output | 1 | Legacy level interrupt pin |

## Verification
A corrupted enable bit shows up at the ports within one cycle of the next event: the pin appears when it should not, or a message appears without bus mastering. A wrong outstanding flag or deferred count shows up as a missing or surplus pulse on the next accepted acknowledgement. A register that takes a masked byte, or a reserved bit that keeps stored data, is seen on the next read of that DWord. The bench runs a behavioural reference model and compares msg_req, intx_o and the message contents against it on every clock. It also compares every configuration read with the model's register image.

// File: rtl/msi_pkg.sv
package msi_pkg;

    // Software-visible register image of the capability.
    typedef struct packed {
        logic        msi_en;
        logic [2:0]  mme;
        logic [29:0] addr_hi;
        logic [15:0] data;
    } msi_regs_t;

    // Merge new bytes into an old word under per-byte enables.
    function automatic logic [31:0] merge_be(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
        logic [31:0] res;
        res = old_w;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter logic [5:0] CAP_DWORD = 6'h20,
    parameter logic [7:0] CAP_ID    = 8'h05,
    parameter logic [7:0] NEXT_PTR  = 8'h90
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dword,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        msi_en,
    output logic [31:0] msg_addr,
    output logic [15:0] msg_data
);
    localparam logic [5:0] IDX_CTRL = CAP_DWORD;
    localparam logic [5:0] IDX_ADDR = CAP_DWORD + 6'd1;
    localparam logic [5:0] IDX_DATA = CAP_DWORD + 6'd2;

    msi_regs_t regs_d, regs_q;
    logic [31:0] addr_word;
    logic [31:0] addr_new;
    logic [31:0] data_new;

    assign addr_word = {regs_q.addr_hi, 2'b00};

    always_comb begin
        regs_d   = regs_q;
        addr_new = merge_be(addr_word, cfg_wdata, cfg_be);
        data_new = merge_be({16'h0000, regs_q.data}, cfg_wdata, cfg_be);
        if (cfg_wr) begin
            if (cfg_dword == IDX_CTRL) begin
                if (cfg_be[2]) begin
                    regs_d.msi_en = cfg_wdata[16];
                    regs_d.mme    = cfg_wdata[22:20];
                end
            end else if (cfg_dword == IDX_ADDR) begin
                regs_d.addr_hi = addr_new[31:2];
            end else if (cfg_dword == IDX_DATA) begin
                regs_d.data = data_new[15:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_rdata = 32'h0;
        if (cfg_dword == IDX_CTRL) begin
            cfg_rdata = {8'h00, 1'b0, regs_q.mme, 3'b000, regs_q.msi_en,
                         NEXT_PTR, CAP_ID};
        end else if (cfg_dword == IDX_ADDR) begin
            cfg_rdata = addr_word;
        end else if (cfg_dword == IDX_DATA) begin
            cfg_rdata = {16'h0000, regs_q.data};
        end
    end

    assign msi_en   = regs_q.msi_en;
    assign msg_addr = addr_word;
    assign msg_data = regs_q.data;

    AST_BE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dword == IDX_CTRL && !cfg_be[2])
        |=> ($stable(regs_q.msi_en) && $stable(regs_q.mme))); // R6

endmodule

// File: rtl/msi_deliver.sv
module msi_deliver #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_event,
    input  logic msi_en,
    input  logic bus_master_en,
    input  logic msg_ack,
    output logic msg_req,
    output logic intx_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             prev;
        logic             pend;
        logic             req;
        logic             intx;
        logic [CNT_W-1:0] cnt;
    } dlv_state_t;

    dlv_state_t st_d, st_q;
    logic             deliver_ok;
    logic             rise;
    logic [CNT_W-1:0] cnt_t;

    assign deliver_ok = msi_en & bus_master_en;
    assign rise       = irq_event & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_event;
        st_d.req  = 1'b0;
        st_d.intx = irq_event & ~msi_en;
        cnt_t     = '0;
        if (!st_q.pend) begin
            st_d.cnt = '0;
            if (rise && deliver_ok) begin
                st_d.req  = 1'b1;
                st_d.pend = 1'b1;
            end
        end else begin
            cnt_t = deliver_ok ? st_q.cnt : '0;
            if (deliver_ok && rise && cnt_t != CNT_MAX) cnt_t = cnt_t + CNT_ONE;
            if (msg_ack && !st_q.req) begin
                if (cnt_t != '0) begin
                    st_d.req = 1'b1;
                    cnt_t    = cnt_t - CNT_ONE;
                end else begin
                    st_d.pend = 1'b0;
                end
            end
            st_d.cnt = cnt_t;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_req = st_q.req;
    assign intx_o  = st_q.intx;

    AST_REQ_NEEDS_BME: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(msi_en && bus_master_en)); // R11

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |=> !msg_req); // R10

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> !intx_o); // R9

    AST_IDLE_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> (st_q.cnt == '0)); // R12

endmodule

// File: rtl/msi_irq_dispatch.sv
module msi_irq_dispatch #(
    parameter logic [5:0] CAP_DWORD = 6'h20,
    parameter logic [7:0] CAP_ID    = 8'h05,
    parameter logic [7:0] NEXT_PTR  = 8'h90,
    parameter int         CNT_W     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dword,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        bus_master_en,
    input  logic        irq_event,
    input  logic        msg_ack,
    output logic        msg_req,
    output logic [31:0] msg_addr,
    output logic [15:0] msg_data,
    output logic        intx_o
);
    logic msi_en;

    msi_cfg_regs #(
        .CAP_DWORD (CAP_DWORD),
        .CAP_ID    (CAP_ID),
        .NEXT_PTR  (NEXT_PTR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dword (cfg_dword),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .msi_en    (msi_en),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    msi_deliver #(
        .CNT_W (CNT_W)
    ) dlv_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_event     (irq_event),
        .msi_en        (msi_en),
        .bus_master_en (bus_master_en),
        .msg_ack       (msg_ack),
        .msg_req       (msg_req),
        .intx_o        (intx_o)
    );

    AST_MSG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (msg_addr[1:0] == 2'b00)); // R4

endmodule

// File: tb/msi_irq_dispatch_tb.sv
module msi_irq_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_MAX    = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dword = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_master_en = 1'b0;
    logic        irq_event = 1'b0;
    logic        msg_ack = 1'b0;
    logic        msg_req;
    logic [31:0] msg_addr;
    logic [15:0] msg_data;
    logic        intx_o;

    int    checks = 0;
    int    errors = 0;
    bit    run = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    bit          m_en;
    bit [2:0]    m_mme;
    bit [31:0]   m_addr;
    bit [15:0]   m_data;
    bit          m_prev, m_pend, m_req, m_intx;
    int          m_cnt;
    int          pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_irq_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dword(cfg_dword),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_master_en(bus_master_en), .irq_event(irq_event), .msg_ack(msg_ack),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .intx_o(intx_o)
    );

    function automatic bit [31:0] model_read(input bit [5:0] idx);
        case (idx)
            6'h20:   return {8'h00, 1'b0, m_mme, 3'b000, m_en, 8'h90, 8'h05};
            6'h21:   return m_addr;
            6'h22:   return {16'h0000, m_data};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_mme = 0; m_addr = 0; m_data = 0;
            m_prev = 0; m_pend = 0; m_req = 0; m_intx = 0; m_cnt = 0;
        end else begin
            bit ok, rise, nreq;
            int c;
            ok   = m_en && bus_master_en;
            rise = irq_event && !m_prev;
            nreq = 0;
            if (!m_pend) begin
                m_cnt = 0;
                if (rise && ok) begin nreq = 1; m_pend = 1; end
            end else begin
                c = ok ? m_cnt : 0;
                if (ok && rise && c < CNT_MAX) c++;
                if (msg_ack && !m_req) begin
                    if (c > 0) begin nreq = 1; c--; end
                    else m_pend = 0;
                end
                m_cnt = c;
            end
            m_req  = nreq;
            m_intx = irq_event && !m_en;
            m_prev = irq_event;
            if (cfg_wr) begin
                if (cfg_dword == 6'h20 && cfg_be[2]) begin
                    m_en  = cfg_wdata[16];
                    m_mme = cfg_wdata[22:20];
                end else if (cfg_dword == 6'h21) begin
                    for (int b = 0; b < 4; b++)
                        if (cfg_be[b]) m_addr[8*b +: 8] = cfg_wdata[8*b +: 8];
                    m_addr[1:0] = 2'b00;
                end else if (cfg_dword == 6'h22) begin
                    for (int b = 0; b < 2; b++)
                        if (cfg_be[b]) m_data[8*b +: 8] = cfg_wdata[8*b +: 8];
                end
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            checks++;
            if (msg_req !== m_req || intx_o !== m_intx) begin
                errors++;
                $display("FAIL %s: msg_req=%b exp %b, intx_o=%b exp %b at %0t",
                         cur_req, msg_req, m_req, intx_o, m_intx, $time);
            end
            if (m_req) begin
                pulses++;
                checks++;
                if (msg_addr !== m_addr || msg_data !== m_data) begin
                    errors++;
                    $display("FAIL %s: msg_addr=%h exp %h, msg_data=%h exp %h",
                             cur_req, msg_addr, m_addr, msg_data, m_data);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input bit [5:0] idx, input bit [3:0] be, input bit [31:0] d);
        cfg_wr = 1; cfg_dword = idx; cfg_be = be; cfg_wdata = d;
        tick(1);
        cfg_wr = 0; cfg_be = 0;
    endtask

    task automatic cfg_check(input bit [5:0] idx, input string tag);
        bit [31:0] exp;
        cfg_dword = idx;
        #1;
        exp = model_read(idx);
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read idx %h got %h exp %h", tag, idx, cfg_rdata, exp);
        end
    endtask

    task automatic expect_val(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic irq_pulse(input int hi, input int lo);
        irq_event = 1; tick(hi);
        irq_event = 0; tick(lo);
    endtask

    task automatic ack(input int n);
        msg_ack = 1; tick(n);
        msg_ack = 0;
    endtask

    initial begin
        int p0;
        tick(3);
        rst_n = 1;
        tick(1);
        run = 1;
        // R1: reset image and outputs
        cur_req = "R1";
        expect_val(int'(msg_req), 0, "R1");
        expect_val(int'(intx_o), 0, "R1");
        cfg_check(6'h20, "R1");
        cfg_check(6'h21, "R1");
        cfg_check(6'h22, "R1");

        // R2, R3: read-only identifier, reserved control bits
        cur_req = "R2";
        cfg_write(6'h20, 4'hF, 32'hFFFF_FFFF);
        cfg_check(6'h20, "R2");
        cfg_check(6'h20, "R3");
        cfg_write(6'h20, 4'hF, 32'h0000_0000);
        cfg_check(6'h20, "R3");

        // R4, R5: address and data registers
        cur_req = "R4";
        cfg_write(6'h21, 4'hF, 32'hFFFF_FFFF);
        cfg_check(6'h21, "R4");
        cfg_write(6'h22, 4'hF, 32'hFFFF_FFFF);
        cfg_check(6'h22, "R5");

        // R6: byte enables
        cur_req = "R6";
        cfg_write(6'h21, 4'b0101, 32'h1234_5678);
        cfg_check(6'h21, "R6");
        cfg_write(6'h22, 4'b0010, 32'h0000_A5C3);
        cfg_check(6'h22, "R6");
        cfg_write(6'h20, 4'b1011, 32'h0071_0000);
        cfg_check(6'h20, "R6");

        // R7: unimplemented offsets
        cur_req = "R7";
        cfg_write(6'h23, 4'hF, 32'hDEAD_BEEF);
        cfg_write(6'h00, 4'hF, 32'hDEAD_BEEF);
        cfg_write(6'h1F, 4'hF, 32'hDEAD_BEEF);
        cfg_check(6'h23, "R7");
        cfg_check(6'h1F, "R7");
        cfg_check(6'h20, "R7");
        cfg_check(6'h21, "R7");
        cfg_check(6'h22, "R7");

        // R8: legacy pin path, bus mastering on and off
        cur_req = "R8";
        bus_master_en = 1;
        irq_pulse(3, 2);
        bus_master_en = 0;
        irq_pulse(1, 3);
        expect_val(pulses, 0, "R8");

        // R11: messages on, bus mastering off
        cur_req = "R11";
        cfg_write(6'h21, 4'hF, 32'hFEE0_1004);
        cfg_write(6'h22, 4'h3, 32'h0000_4041);
        cfg_write(6'h20, 4'h4, 32'h0001_0000);
        irq_pulse(2, 2);
        irq_pulse(1, 3);
        expect_val(pulses, 0, "R11");

        // R9, R10: single delivery, no pin
        cur_req = "R10";
        bus_master_en = 1;
        p0 = pulses;
        irq_event = 1; tick(4);
        expect_val(int'(intx_o), 0, "R9");
        irq_event = 0; tick(2);
        expect_val(pulses - p0, 1, "R10");
        ack(1); tick(2);

        // R12: deferral, ack during pulse, stray acks
        cur_req = "R12";
        p0 = pulses;
        ack(1);
        irq_event = 1; tick(1);
        ack(1);
        irq_event = 0; tick(1);
        irq_pulse(1, 1);
        irq_pulse(1, 1);
        expect_val(pulses - p0, 1, "R12");
        ack(1); tick(3);
        ack(1); tick(3);
        expect_val(pulses - p0, 3, "R12");
        ack(2); tick(3);
        expect_val(pulses - p0, 3, "R12");

        // R13: multiple-message-enable has no effect
        cur_req = "R13";
        cfg_write(6'h20, 4'h4, 32'h0051_0000);
        cfg_check(6'h20, "R13");
        cfg_write(6'h22, 4'h3, 32'h0000_0BAD);
        p0 = pulses;
        irq_pulse(2, 2);
        ack(1); tick(2);
        irq_pulse(1, 1);
        ack(1); tick(2);
        expect_val(pulses - p0, 2, "R13");

        // R14: disabling discards deferred edges
        cur_req = "R14";
        p0 = pulses;
        irq_pulse(1, 1);
        irq_pulse(1, 1);
        irq_pulse(1, 1);
        bus_master_en = 0; tick(2);
        bus_master_en = 1; tick(1);
        ack(1); tick(3);
        ack(1); tick(3);
        expect_val(pulses - p0, 1, "R14");
        cfg_write(6'h20, 4'h4, 32'h0000_0000);
        cur_req = "R8";
        irq_pulse(2, 3);

        run = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule